// File: doc/BRIEF.md
# Twisted-Pair Link Integrity Monitor

This block decides whether a twisted-pair Ethernet link can be used. It does not look at the analog signal. The receive front end hands it already-qualified events: a strobe for each detected link beat pulse together with that pulse's polarity, and a flag for valid receive data. From these events the block keeps a two-state link verdict, Fail or Pass, and drives a status output that can light an LED directly.

While the verdict is Fail, the block closes the transmit, receive, loopback and collision-detect paths. If a transmit is attempted in that state, nothing reaches the medium and a loss-of-carrier flag and a collision-error flag are raised. A configuration input turns the link test off, which leaves every path open.

The block also times the outgoing link beat pulses. These are sent whenever the transmitter is idle, whatever the verdict and whatever the configuration.

Top module: `tp_link_monitor`

## Requirements
- R1: After reset the verdict is Fail: `link_up_o`, all path enables, `tx_out_o`, both error flags and `beat_tx_o` are low.
- R2: In Fail with the test enabled, all path enables are low. The verdict moves to Pass on the clock edge that samples `rx_act_i` high, or on the edge that samples the RUN_LEN-th (default 6) pulse of a consecutive run. From that edge on, all path enables are high.
- R3: Two pulses are consecutive when they have the same polarity and the strobe of the second is sampled G edges after the first, with GAP_MIN <= G <= GAP_MAX. A pulse that breaks either rule starts a new run of length one.
- R4: A 0-to-1 change of `tp_sel_i` (alternate port to twisted pair) forces Fail on the edge that samples it. A 1-to-0 change leaves the verdict unchanged.
- R5: While the verdict is Fail and the test is enabled, `tx_out_o` stays low whatever `tx_req_i` is. Each edge that samples `tx_req_i` high raises both `carrier_err_o` and `col_err_o` for the following cycle.
- R6: With `test_dis_i` high, all path enables are high in either verdict, `tx_out_o` follows `tx_req_i`, and neither error flag is raised.
- R7: While `tx_idle_i` is high, `beat_tx_o` pulses high for one cycle every BEAT_TICKS cycles, independent of the verdict and of `test_dis_i`.
- R8: While `tx_idle_i` is low, `beat_tx_o` stays low. The first pulse after idle returns appears BEAT_TICKS cycles after the first edge that samples `tx_idle_i` high.
- R9: In Pass, if LOSS_TICKS edges go by after the last edge that sampled receive data or an accepted pulse, the verdict returns to Fail on the next edge.
- R10: On entry to Pass through a pulse run, `rx_pol_neg_o` takes the run's polarity (1 = negative). Afterwards, in Pass, pulses of the other polarity do not restart the loss timer.
- R11: `link_up_o` is high exactly while the verdict is Pass, and it is meant to drive the link LED.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| beat_rx_i | input | 1 | One-cycle strobe: link beat pulse detected |
| beat_rx_neg_i | input | 1 | Polarity of the detected pulse, 1 = negative |
| rx_act_i | input | 1 | Valid receive data seen |
| tx_idle_i | input | 1 | Transmitter has no data to send |
| tp_sel_i | input | 1 | 1 = twisted-pair port selected, 0 = alternate port |
| test_dis_i | input | 1 | 1 = link test disabled |
| tx_req_i | input | 1 | Transmit attempt |
| link_up_o | output | 1 | Link status (Pass), LED drive |
| tx_en_o | output | 1 | Transmit driver enable |
| rx_en_o | output | 1 | Receive path enable |
| lpbk_en_o | output | 1 | Loopback enable |
| col_en_o | output | 1 | Collision detect enable |
| tx_out_o | output | 1 | Transmit attempt passed to the medium |
| carrier_err_o | output | 1 | Loss-of-carrier error flag |
| col_err_o | output | 1 | Collision-error flag |
| rx_pol_neg_o | output | 1 | Locked receive polarity, 1 = negative |
| beat_tx_o | output | 1 | One-cycle strobe: send a link beat pulse |

## Verification
The bench scales every time window down to tens of clock cycles: GAP_MIN=8, GAP_MAX=60, BEAT_TICKS=40, LOSS_TICKS=200, with RUN_LEN left at 6. With these values, both edges of the pulse-spacing window can be probed exactly (spacings 7, 8, 60 and 61). The loss timeout can be hit on its exact cycle, and several beat periods fit into a short run. Runs broken by a polarity change, runs that are too short, and port switches in both directions are covered by a vector table.

// File: rtl/tplm_pkg.sv
// Package: shared types for the twisted-pair link monitor.
// Assumes: nothing beyond a two-state link verdict.
package tplm_pkg;

    typedef enum logic {
        LINK_FAIL = 1'b0,
        LINK_PASS = 1'b1
    } link_st_t;

endpackage

// File: rtl/tplm_pulse_qual.sv
// Module: counts consecutive received link pulses of one polarity whose
// spacing lies inside [GAP_MIN, GAP_MAX] sampled edges. It raises qual_o
// on the pulse that completes a run of RUN_LEN.
// Assumes: pulse_i is a one-cycle strobe, GAP_MIN >= 1, and GAP_MAX > GAP_MIN.
module tplm_pulse_qual #(
    parameter int GAP_MIN = 50000,
    parameter int GAP_MAX = 600000,
    parameter int RUN_LEN = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic pulse_i,
    input  logic pulse_neg_i,
    output logic qual_o,
    output logic qual_neg_o
);
    localparam int GW = $clog2(GAP_MAX + 1);
    localparam int RW = $clog2(RUN_LEN + 1);

    logic [GW-1:0] gap_q;
    logic [RW-1:0] run_q;
    logic          pol_q;
    logic          gap_ok;
    logic          extend;

    // Spacing and polarity test for the pulse now arriving.
    always_comb begin
        gap_ok = (gap_q >= GW'(GAP_MIN - 1)) && (gap_q <= GW'(GAP_MAX - 1));
        extend = (run_q != '0) && (pulse_neg_i == pol_q) && gap_ok;
        qual_o = pulse_i && !clr_i && extend && (run_q == RW'(RUN_LEN - 1));
        qual_neg_o = pol_q;
    end

    // Tracks the run length, its polarity, and the edges since the last pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_q <= '0;
            run_q <= '0;
            pol_q <= 1'b0;
        end else if (clr_i) begin
            gap_q <= '0;
            run_q <= '0;
        end else if (pulse_i) begin
            gap_q <= '0;
            run_q <= extend ? RW'(run_q + 1'b1) : RW'(1);
            pol_q <= pulse_neg_i;
        end else if (gap_q != GW'(GAP_MAX)) begin
            gap_q <= GW'(gap_q + 1'b1);
        end else begin
            run_q <= '0;
        end
    end

endmodule

// File: rtl/tplm_loss_timer.sv
// Module: link-loss watchdog. While run_i is high it counts edges since the
// last kick and raises expire_o once LOSS_TICKS edges have gone by unkicked.
// Assumes: LOSS_TICKS >= 2.
module tplm_loss_timer #(
    parameter int LOSS_TICKS = 2500000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic kick_i,
    output logic expire_o
);
    localparam int LW = $clog2(LOSS_TICKS);

    logic [LW-1:0] cnt_q;

    // Timeout decision for the current cycle.
    always_comb expire_o = run_i && !kick_i && (cnt_q == LW'(LOSS_TICKS - 1));

    // Counts idle edges while the link is in Pass.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i || kick_i) begin
            cnt_q <= '0;
        end else if (!expire_o) begin
            cnt_q <= LW'(cnt_q + 1'b1);
        end
    end

endmodule

// File: rtl/tplm_beat_gen.sv
// Module: timer for the outgoing link beat pulses. Emits one strobe every
// PERIOD cycles while the transmitter is idle, and restarts from zero when
// transmit activity ends.
// Assumes: PERIOD >= 2.
module tplm_beat_gen #(
    parameter int PERIOD = 400000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic idle_i,
    output logic beat_o
);
    localparam int PW = $clog2(PERIOD);

    logic [PW-1:0] cnt_q;
    logic          wrap;

    // Marks the last count of a period.
    always_comb wrap = (cnt_q == PW'(PERIOD - 1));

    // Period counter, held at zero while transmitting; the strobe is registered.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            beat_o <= 1'b0;
        end else if (!idle_i) begin
            cnt_q  <= '0;
            beat_o <= 1'b0;
        end else begin
            cnt_q  <= wrap ? '0 : PW'(cnt_q + 1'b1);
            beat_o <= wrap;
        end
    end

endmodule

// File: rtl/tp_link_monitor.sv
// Module: twisted-pair link integrity monitor (top). Holds the Fail/Pass
// verdict, gates the data paths, flags transmit attempts made in Fail,
// locks the receive polarity and drives the link beat pulse timer.
// Assumes: all inputs are synchronous to clk; beat_rx_i is a one-cycle strobe.
module tp_link_monitor
    import tplm_pkg::*;
#(
    parameter int GAP_MIN    = 50000,
    parameter int GAP_MAX    = 600000,
    parameter int RUN_LEN    = 6,
    parameter int BEAT_TICKS = 400000,
    parameter int LOSS_TICKS = 2500000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic beat_rx_i,
    input  logic beat_rx_neg_i,
    input  logic rx_act_i,
    input  logic tx_idle_i,
    input  logic tp_sel_i,
    input  logic test_dis_i,
    input  logic tx_req_i,
    output logic link_up_o,
    output logic tx_en_o,
    output logic rx_en_o,
    output logic lpbk_en_o,
    output logic col_en_o,
    output logic tx_out_o,
    output logic carrier_err_o,
    output logic col_err_o,
    output logic rx_pol_neg_o,
    output logic beat_tx_o
);
    link_st_t st_q, st_d;
    logic     sel_q;
    logic     pol_q;
    logic     err_q;
    logic     sel_rise;
    logic     in_pass;
    logic     path_open;
    logic     kick;
    logic     qual, qual_neg;
    logic     expire;

    // Derived conditions for the current cycle.
    always_comb begin
        in_pass   = (st_q == LINK_PASS);
        sel_rise  = tp_sel_i && !sel_q;
        path_open = in_pass || test_dis_i;
        kick      = rx_act_i || (beat_rx_i && (beat_rx_neg_i == pol_q));
    end

    tplm_pulse_qual #(
        .GAP_MIN(GAP_MIN),
        .GAP_MAX(GAP_MAX),
        .RUN_LEN(RUN_LEN)
    ) u_qual (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_i      (in_pass || sel_rise),
        .pulse_i    (beat_rx_i),
        .pulse_neg_i(beat_rx_neg_i),
        .qual_o     (qual),
        .qual_neg_o (qual_neg)
    );

    tplm_loss_timer #(
        .LOSS_TICKS(LOSS_TICKS)
    ) u_loss (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_i   (in_pass),
        .kick_i  (kick),
        .expire_o(expire)
    );

    tplm_beat_gen #(
        .PERIOD(BEAT_TICKS)
    ) u_beat (
        .clk   (clk),
        .rst_n (rst_n),
        .idle_i(tx_idle_i),
        .beat_o(beat_tx_o)
    );

    // Next verdict: a port switch wins, then entry to Pass, then loss of link.
    always_comb begin
        st_d = st_q;
        if (sel_rise) begin
            st_d = LINK_FAIL;
        end else if (!in_pass) begin
            if (rx_act_i || qual) st_d = LINK_PASS;
        end else if (expire) begin
            st_d = LINK_FAIL;
        end
    end

    // Verdict, port-select history, locked polarity and error flag registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= LINK_FAIL;
            sel_q <= 1'b0;
            pol_q <= 1'b0;
            err_q <= 1'b0;
        end else begin
            st_q  <= st_d;
            sel_q <= tp_sel_i;
            err_q <= tx_req_i && !path_open;
            if (!in_pass && !sel_rise && qual) pol_q <= qual_neg;
        end
    end

    // Port drive.
    always_comb begin
        link_up_o     = in_pass;
        tx_en_o       = path_open;
        rx_en_o       = path_open;
        lpbk_en_o     = path_open;
        col_en_o      = path_open;
        tx_out_o      = tx_req_i && path_open;
        carrier_err_o = err_q;
        col_err_o     = err_q;
        rx_pol_neg_o  = pol_q;
    end

endmodule

// File: rtl/tplm_checker.sv
// Module: temporal checks on the link monitor's ports, attached by bind.
// Assumes: clocked with the monitor; all checks are off during reset.
module tplm_checker (
    input logic clk,
    input logic rst_n,
    input logic beat_rx_i,
    input logic rx_act_i,
    input logic tx_idle_i,
    input logic tp_sel_i,
    input logic test_dis_i,
    input logic tx_req_i,
    input logic link_up_o,
    input logic rx_en_o,
    input logic carrier_err_o,
    input logic col_err_o,
    input logic beat_tx_o
);

    // R2: the link can come up only after data or a pulse was sampled.
    a_r2_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(link_up_o) |-> $past(rx_act_i || beat_rx_i));

    // R4: switching to the twisted-pair port drops the link.
    a_r4_port_switch: assert property (@(posedge clk) disable iff (!rst_n)
        (tp_sel_i && $past(tp_sel_i) == 1'b0 && $past(rst_n)) |=> !link_up_o);

    // R5: an attempt in Fail raises both error flags.
    a_r5_fail_errors: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_req_i && !link_up_o && !test_dis_i) |=> (carrier_err_o && col_err_o));

    // R6: no error flags while the test is disabled.
    a_r6_no_err_dis: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_req_i && test_dis_i) |=> !carrier_err_o);

    // R7: each beat strobe lasts a single cycle.
    a_r7_beat_single: assert property (@(posedge clk) disable iff (!rst_n)
        beat_tx_o |=> !beat_tx_o);

    // R8: no beat follows a busy transmitter cycle.
    a_r8_quiet_busy: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_idle_i |=> !beat_tx_o);

    // R11: a reported link always has its receive path open.
    a_r11_up_open: assert property (@(posedge clk) disable iff (!rst_n)
        link_up_o |-> rx_en_o);

endmodule

bind tp_link_monitor tplm_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .beat_rx_i    (beat_rx_i),
    .rx_act_i     (rx_act_i),
    .tx_idle_i    (tx_idle_i),
    .tp_sel_i     (tp_sel_i),
    .test_dis_i   (test_dis_i),
    .tx_req_i     (tx_req_i),
    .link_up_o    (link_up_o),
    .rx_en_o      (rx_en_o),
    .carrier_err_o(carrier_err_o),
    .col_err_o    (col_err_o),
    .beat_tx_o    (beat_tx_o)
);

// File: tb/tb_tp_link_monitor.sv
module tb_tp_link_monitor;
    localparam int GMIN = 8;
    localparam int GMAX = 60;
    localparam int RUN  = 6;
    localparam int PER  = 40;
    localparam int LOSS = 200;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic beat_rx = 1'b0, beat_neg = 1'b0, rx_act = 1'b0, tx_idle = 1'b1;
    logic tp_sel = 1'b1, test_dis = 1'b0, tx_req = 1'b0;
    logic link_up, tx_en, rx_en, lpbk_en, col_en, tx_out, c_err, k_err, pol_neg, beat_tx;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    tp_link_monitor #(
        .GAP_MIN(GMIN), .GAP_MAX(GMAX), .RUN_LEN(RUN),
        .BEAT_TICKS(PER), .LOSS_TICKS(LOSS)
    ) dut (
        .clk(clk), .rst_n(rst_n), .beat_rx_i(beat_rx), .beat_rx_neg_i(beat_neg),
        .rx_act_i(rx_act), .tx_idle_i(tx_idle), .tp_sel_i(tp_sel),
        .test_dis_i(test_dis), .tx_req_i(tx_req), .link_up_o(link_up),
        .tx_en_o(tx_en), .rx_en_o(rx_en), .lpbk_en_o(lpbk_en), .col_en_o(col_en),
        .tx_out_o(tx_out), .carrier_err_o(c_err), .col_err_o(k_err),
        .rx_pol_neg_o(pol_neg), .beat_tx_o(beat_tx)
    );

    typedef struct packed {
        logic [3:0] n;
        logic [7:0] gap;
        logic [3:0] flip;
        logic       neg;
        logic       up;
        logic       pol;
    } vec_t;

    // Pulse trains: count, spacing, index of polarity flip (15 = none), start polarity, expected up, expected polarity.
    localparam vec_t VEC [11] = '{
        '{4'd6, 8'd20, 4'd15, 1'b0, 1'b1, 1'b0},
        '{4'd5, 8'd20, 4'd15, 1'b0, 1'b0, 1'b0},
        '{4'd6, 8'd4,  4'd15, 1'b0, 1'b0, 1'b0},
        '{4'd6, 8'd80, 4'd15, 1'b0, 1'b0, 1'b0},
        '{4'd6, 8'd20, 4'd3,  1'b0, 1'b0, 1'b0},
        '{4'd6, 8'd20, 4'd15, 1'b1, 1'b1, 1'b1},
        '{4'd8, 8'd20, 4'd2,  1'b0, 1'b1, 1'b1},
        '{4'd6, 8'd8,  4'd15, 1'b0, 1'b1, 1'b0},
        '{4'd6, 8'd60, 4'd15, 1'b0, 1'b1, 1'b0},
        '{4'd6, 8'd7,  4'd15, 1'b1, 1'b0, 1'b0},
        '{4'd6, 8'd61, 4'd15, 1'b0, 1'b0, 1'b0}
    };

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_pulse(input logic neg);
        beat_rx = 1'b1; beat_neg = neg;
        tick(1);
        beat_rx = 1'b0;
    endtask

    task automatic train(input int n, input int gap, input int flip, input logic neg);
        for (int i = 0; i < n; i++) begin
            send_pulse(neg ^ (i >= flip));
            if (i < n - 1) tick(gap - 1);
        end
    endtask

    task automatic force_fail();
        tp_sel = 1'b0; tick(1);
        tp_sel = 1'b1; tick(1);
    endtask

    task automatic wait_beat(output int n);
        n = 0;
        do begin
            tick(1); n++;
        end while (!beat_tx && n < 1000);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int n;
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // R1 reset state
        check("R1 link_up", link_up, 0);
        check("R1 enables", tx_en | rx_en | lpbk_en | col_en, 0);
        check("R1 errors", c_err | k_err, 0);
        check("R1 beat", beat_tx, 0);

        // R3 R2 R10 table of pulse trains
        foreach (VEC[k]) begin
            force_fail();
            train(int'(VEC[k].n), int'(VEC[k].gap), int'(VEC[k].flip), VEC[k].neg);
            check($sformatf("R3 vec%0d link_up", k), link_up, int'(VEC[k].up));
            check($sformatf("R2 vec%0d rx_en", k), rx_en, int'(VEC[k].up));
            if (VEC[k].up) check($sformatf("R10 vec%0d polarity", k), pol_neg, int'(VEC[k].pol));
        end

        // R2 a five-pulse run leaves the link down, and receive data brings it up
        force_fail();
        train(5, 20, 15, 1'b0);
        check("R2 five pulses", link_up, 0);
        rx_act = 1'b1; tick(1); rx_act = 1'b0;
        check("R2 data entry", link_up, 1);
        check("R11 led follows", link_up & col_en & lpbk_en & tx_en, 1);

        // R4 port switch in both directions
        tp_sel = 1'b0; tick(1);
        check("R4 to alternate keeps", link_up, 1);
        tp_sel = 1'b1; tick(1);
        check("R4 to twisted pair drops", link_up, 0);

        // R5 transmit attempt during Fail
        tx_req = 1'b1; #1;
        check("R5 tx blocked", tx_out, 0);
        tick(1); tx_req = 1'b0;
        check("R5 carrier err", c_err, 1);
        check("R5 collision err", k_err, 1);
        tick(1);
        check("R5 flag clears", c_err, 0);

        // R6 test disabled opens every path in Fail
        test_dis = 1'b1; #1;
        check("R6 enables", tx_en & rx_en & lpbk_en & col_en, 1);
        check("R6 link still down", link_up, 0);
        tx_req = 1'b1; #1;
        check("R6 tx passes", tx_out, 1);
        tick(1); tx_req = 1'b0;
        check("R6 no error", c_err | k_err, 0);

        // R7 beat spacing with the test disabled and with it enabled
        wait_beat(n);
        wait_beat(n);
        check("R7 period disabled", n, PER);
        test_dis = 1'b0;
        wait_beat(n);
        check("R7 period enabled", n, PER);

        // R8 silence while busy, restart after idle returns
        tx_idle = 1'b0;
        n = 0;
        for (int i = 0; i < 100; i++) begin
            tick(1);
            if (beat_tx) n++;
        end
        check("R8 silent while busy", n, 0);
        tx_idle = 1'b1;
        wait_beat(n);
        check("R8 restart delay", n, PER);

        // R9 loss timer refreshed by locked-polarity pulses
        force_fail();
        train(6, 20, 15, 1'b0);
        check("R9 up", link_up, 1);
        for (int r = 0; r < 3; r++) begin
            tick(150);
            send_pulse(1'b0);
        end
        check("R9 refreshed", link_up, 1);
        tick(LOSS - 1);
        check("R9 last cycle up", link_up, 1);
        tick(1);
        check("R9 timeout", link_up, 0);

        // R10 opposite-polarity pulses do not refresh
        force_fail();
        train(6, 20, 15, 1'b0);
        for (int r = 0; r < 5; r++) begin
            tick(49);
            send_pulse(1'b1);
        end
        check("R10 opposite ignored", link_up, 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule